// File: doc/BRIEF.md
# Memory Protection Region Checker

This block decides whether a single memory access may proceed. It holds eight programmable protection windows. Each window is a power-of-two span with an enable bit, a size code and an aligned base. It also holds two permission words, one for data accesses and one for instruction fetches, with a 4-bit code per window in each. Given an address, an access kind and a privilege flag, the block reports allow or deny in the same cycle. It also reports whether any window contains the address and which one has the highest index.

Software or a control sequencer loads the configuration through a single-cycle write port. A selector picks one of the ten registers. A new value governs decisions from the cycle after the write. A global enable input bypasses all checking when it is low.

Top module: `mpu_region_checker`

## Requirements
- R1: After reset all window words are 0 and both permission words are 0x22222222, so with prot_en_i high no window matches, allow_o is 0, hit_o is 0 and hit_idx_o is 0.
- R2: In a window word, bit 0 enables the window and bits 5:1 hold a size code N that gives a span of 2^(N+1) bytes. The window contains an address when the address equals the word in all bits at or above bit max(N+1, 6). Bits 5:0 are never compared.
- R3: Size code 31 on an enabled window contains every 32-bit address.
- R4: A window whose bit 0 is clear contains no address, whatever its other bits hold.
- R5: The data permission code of window n sits in bits 4n+3:4n of the data permission word, and it decides reads and writes. Code 1 gives privileged read/write and no user access. Code 2 gives privileged read/write and user read. Code 3 gives read/write in both modes. Code 5 gives privileged read only. Code 6 gives read only in both modes. Codes 0, 4 and 7 to 15 deny.
- R6: The instruction permission code of window n sits in the same bit position of the instruction permission word, and it decides execute. Code 1 allows privileged execute only. Codes 2, 3 and 6 allow execute in both modes. All other codes deny.
- R7: When prot_en_i is 0, allow_o is 1 for every access.
- R8: When prot_en_i is 1, allow_o is 1 exactly when at least one containing window grants the access. A lower-numbered window that grants it wins over a higher-numbered containing window that denies it.
- R9: hit_o is 1 when any enabled window contains the address. hit_idx_o then gives the highest such window index; otherwise it is 0. Neither output depends on permissions or on prot_en_i.
- R10: Write selector values 0 to 7 address window words 0 to 7. Value 8 addresses the data permission word and 9 the instruction permission word. Values 10 to 15 change nothing. A write changes decisions from the next cycle.
- R11: kind_i encodes 0 read, 1 write, 2 execute, and 3 reserved. priv_i is 1 for privileged, 0 for user. A reserved kind is denied while protection is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_sel_i | input | 4 | Configuration register selector |
| wr_data_i | input | 32 | Configuration write value |
| prot_en_i | input | 1 | Global protection enable |
| addr_i | input | 32 | Access address |
| kind_i | input | 2 | Access kind: read, write, execute, reserved |
| priv_i | input | 1 | 1 for privileged, 0 for user access |
| allow_o | output | 1 | Access permitted |
| hit_o | output | 1 | Some enabled window contains the address |
| hit_idx_o | output | 3 | Highest containing window index |

## Verification
A corrupted window word or mask shows up on hit_o and hit_idx_o at once for any address near the window edge, so probes just inside and just outside each span expose it within one check. A wrong permission field or decode flips allow_o only for the particular code, kind and privilege combination, so every code is swept against every kind and both modes through a whole-space window. Stale or misrouted register writes appear on the first access after the write, which the bench probes in the very next cycle.

// File: rtl/mpu_pkg.sv
package mpu_pkg;
  localparam int unsigned NUM_REGIONS = 8;
  localparam int unsigned ADDR_W      = 32;
  localparam int unsigned PERM_W      = 4;
  localparam int unsigned LOW_IGNORE  = 6;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/mpu_cfg_regs.sv
module mpu_cfg_regs #(
  parameter int unsigned NREG = mpu_pkg::NUM_REGIONS,
  parameter int unsigned DW   = mpu_pkg::ADDR_W,
  parameter int unsigned SW   = $clog2(NREG + 2),
  localparam int unsigned PW  = NREG * mpu_pkg::PERM_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [SW-1:0]            wr_sel_i,
  input  logic [DW-1:0]            wr_data_i,
  output logic [NREG-1:0][DW-1:0]  region_o,
  output logic [PW-1:0]            dperm_o,
  output logic [PW-1:0]            iperm_o
);
  localparam logic [PW-1:0] PermRst = {NREG{4'h2}};
  localparam logic [SW-1:0] SelD    = SW'(NREG);
  localparam logic [SW-1:0] SelI    = SW'(NREG + 1);

  for (genvar n = 0; n < NREG; n++) begin : g_region
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 region_o[n] <= '0;
      else if (wr_en_i && wr_sel_i == SW'(n))      region_o[n] <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dperm_o <= PermRst;
      iperm_o <= PermRst;
    end else if (wr_en_i) begin
      if (wr_sel_i == SelD) dperm_o <= wr_data_i[PW-1:0];
      if (wr_sel_i == SelI) iperm_o <= wr_data_i[PW-1:0];
    end
  end
endmodule

// File: rtl/mpu_region_match.sv
module mpu_region_match #(
  parameter int unsigned NREG = mpu_pkg::NUM_REGIONS,
  parameter int unsigned DW   = mpu_pkg::ADDR_W
) (
  input  logic [DW-1:0]            addr_i,
  input  logic [NREG-1:0][DW-1:0]  region_i,
  output logic [NREG-1:0]          match_o
);
  localparam logic [DW-1:0] LowMask = DW'((64'd1 << mpu_pkg::LOW_IGNORE) - 64'd1);

  for (genvar n = 0; n < NREG; n++) begin : g_match
    logic [5:0]    span_exp;
    logic [DW:0]   span;
    logic [DW-1:0] keep_mask;
    // extra bit keeps the full-space span from wrapping to zero
    always_comb begin
      span_exp  = {1'b0, region_i[n][5:1]} + 6'd1;
      span      = (DW+1)'(1) << span_exp;
      keep_mask = ~((span[DW-1:0] - DW'(1)) | LowMask);
      if (span[DW]) keep_mask = '0;
      match_o[n] = region_i[n][0] &&
                   ((addr_i & keep_mask) == (region_i[n] & keep_mask));
    end
  end
endmodule

// File: rtl/mpu_perm_decode.sv
module mpu_perm_decode #(
  parameter int unsigned NREG = mpu_pkg::NUM_REGIONS,
  localparam int unsigned PW  = NREG * mpu_pkg::PERM_W
) (
  input  logic [PW-1:0]         dperm_i,
  input  logic [PW-1:0]         iperm_i,
  input  mpu_pkg::acc_kind_e    kind_i,
  input  logic                  priv_i,
  output logic [NREG-1:0]       ok_o
);
  import mpu_pkg::*;

  for (genvar n = 0; n < NREG; n++) begin : g_perm
    logic [3:0] dc, ic;
    logic       rd_ok, wr_ok, ex_ok;
    assign dc = dperm_i[4*n +: 4];
    assign ic = iperm_i[4*n +: 4];

    always_comb begin
      unique case (dc)
        4'd1:    begin rd_ok = priv_i; wr_ok = priv_i; end
        4'd2:    begin rd_ok = 1'b1;   wr_ok = priv_i; end
        4'd3:    begin rd_ok = 1'b1;   wr_ok = 1'b1;   end
        4'd5:    begin rd_ok = priv_i; wr_ok = 1'b0;   end
        4'd6:    begin rd_ok = 1'b1;   wr_ok = 1'b0;   end
        default: begin rd_ok = 1'b0;   wr_ok = 1'b0;   end
      endcase
      unique case (ic)
        4'd1:                ex_ok = priv_i;
        4'd2, 4'd3, 4'd6:    ex_ok = 1'b1;
        default:             ex_ok = 1'b0;
      endcase
      unique case (kind_i)
        ACC_READ:  ok_o[n] = rd_ok;
        ACC_WRITE: ok_o[n] = wr_ok;
        ACC_EXEC:  ok_o[n] = ex_ok;
        default:   ok_o[n] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/mpu_region_checker.sv
module mpu_region_checker #(
  parameter int unsigned NREG = mpu_pkg::NUM_REGIONS,
  parameter int unsigned DW   = mpu_pkg::ADDR_W,
  localparam int unsigned SW  = $clog2(NREG + 2),
  localparam int unsigned IW  = $clog2(NREG),
  localparam int unsigned PW  = NREG * mpu_pkg::PERM_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [SW-1:0] wr_sel_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          prot_en_i,
  input  logic [DW-1:0] addr_i,
  input  logic [1:0]    kind_i,
  input  logic          priv_i,
  output logic          allow_o,
  output logic          hit_o,
  output logic [IW-1:0] hit_idx_o
);
  logic [NREG-1:0][DW-1:0] region_q;
  logic [PW-1:0]           dperm_q, iperm_q;
  logic [NREG-1:0]         match, perm_ok, grant;

  mpu_cfg_regs #(.NREG(NREG), .DW(DW), .SW(SW)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i,
    .region_o(region_q), .dperm_o(dperm_q), .iperm_o(iperm_q)
  );

  mpu_region_match #(.NREG(NREG), .DW(DW)) u_match (
    .addr_i, .region_i(region_q), .match_o(match)
  );

  mpu_perm_decode #(.NREG(NREG)) u_perm (
    .dperm_i(dperm_q), .iperm_i(iperm_q),
    .kind_i(mpu_pkg::acc_kind_e'(kind_i)), .priv_i, .ok_o(perm_ok)
  );

  assign grant   = match & perm_ok;
  assign allow_o = !prot_en_i || (|grant);

  always_comb begin
    hit_o     = 1'b0;
    hit_idx_o = '0;
    for (int n = 0; n < NREG; n++) begin
      if (match[n]) begin
        hit_o     = 1'b1;
        hit_idx_o = IW'(n);
      end
    end
  end
endmodule

// File: rtl/mpu_region_checker_sva.sv
module mpu_region_checker_sva #(
  parameter int unsigned SW = 4,
  parameter int unsigned DW = 32,
  parameter int unsigned IW = 3,
  parameter int unsigned PW = 32,
  parameter int unsigned NREG = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_en_i,
  input logic [SW-1:0] wr_sel_i,
  input logic [DW-1:0] wr_data_i,
  input logic          prot_en_i,
  input logic [1:0]    kind_i,
  input logic          allow_o,
  input logic          hit_o,
  input logic [IW-1:0] hit_idx_o,
  input logic [PW-1:0] dperm_q
);
  a_r7_bypass_allows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prot_en_i |-> allow_o);

  a_r8_allow_needs_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prot_en_i && allow_o) |-> hit_o);

  a_r9_idx_zero_on_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (hit_idx_o == '0));

  a_r11_reserved_denied: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prot_en_i && kind_i == 2'd3) |-> !allow_o);

  a_r10_dperm_write_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == SW'(NREG)) |=> (dperm_q == $past(wr_data_i[PW-1:0])));
endmodule

bind mpu_region_checker mpu_region_checker_sva #(
  .SW(SW), .DW(DW), .IW(IW), .PW(PW), .NREG(NREG)
) u_sva (
  .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i, .prot_en_i, .kind_i,
  .allow_o, .hit_o, .hit_idx_o, .dperm_q(dperm_q)
);

// File: tb/sim_mpu_region_checker.sv
module sim_mpu_region_checker;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [3:0]  wr_sel_i = '0;
  logic [31:0] wr_data_i = '0;
  logic        prot_en_i = 1'b0;
  logic [31:0] addr_i = '0;
  logic [1:0]  kind_i = '0;
  logic        priv_i = 1'b0;
  logic        allow_o, hit_o;
  logic [2:0]  hit_idx_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  mpu_region_checker u0 (
    .clk_i(clk), .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i, .prot_en_i,
    .addr_i, .kind_i, .priv_i, .allow_o, .hit_o, .hit_idx_o
  );

  typedef struct {
    logic       allow;
    logic       hit;
    logic [2:0] idx;
    string      tag;
  } exp_t;
  exp_t sb[$];

  logic [31:0] m_reg [8];
  logic [31:0] m_dperm, m_iperm;

  function automatic logic m_contains(logic [31:0] w, logic [31:0] a);
    logic [63:0] span;
    logic [31:0] keep;
    if (!w[0]) return 1'b0;
    if (w[5:1] == 5'd31) return 1'b1;
    span = 64'd1 << (w[5:1] + 1);
    keep = ~(span[31:0] - 32'd1) & 32'hFFFF_FFC0;
    return (a & keep) == (w & keep);
  endfunction

  function automatic logic m_perm(logic [3:0] dc, logic [3:0] ic, logic [1:0] k, logic pv);
    logic wr;
    wr = (k == 2'd1);
    if (k == 2'd3) return 1'b0;
    if (k == 2'd2) return (ic == 4'd1) ? pv : (ic == 4'd2 || ic == 4'd3 || ic == 4'd6);
    case (dc)
      4'd1: return pv;
      4'd2: return pv | !wr;
      4'd3: return 1'b1;
      4'd5: return pv & !wr;
      4'd6: return !wr;
      default: return 1'b0;
    endcase
  endfunction

  task automatic wr_cfg(input logic [3:0] sel, input logic [31:0] val);
    @(negedge clk);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = val;
    if (sel < 4'd8) m_reg[sel[2:0]] = val;
    else if (sel == 4'd8) m_dperm = val;
    else if (sel == 4'd9) m_iperm = val;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic probe(input logic [31:0] a, input logic [1:0] k, input logic pv,
                       input logic en, input string tag);
    exp_t e;
    @(negedge clk);
    wr_en_i = 1'b0;
    addr_i = a; kind_i = k; priv_i = pv; prot_en_i = en;
    e.allow = !en; e.hit = 1'b0; e.idx = '0; e.tag = tag;
    for (int n = 0; n < 8; n++) begin
      if (m_contains(m_reg[n], a)) begin
        e.hit = 1'b1; e.idx = 3'(n);
        if (m_perm(m_dperm[4*n +: 4], m_iperm[4*n +: 4], k, pv)) e.allow = 1'b1;
      end
    end
    sb.push_back(e);
  endtask

  // fixed expectation on top of the model
  task automatic probe_fix(input logic [31:0] a, input logic [1:0] k, input logic pv,
                           input logic al, input logic ht, input logic [2:0] ix, input string tag);
    probe(a, k, pv, 1'b1, tag);
    if (sb[$].allow !== al || sb[$].hit !== ht || sb[$].idx !== ix) begin
      errors++;
      $display("FAIL %s model disagrees with requirement: model %b%b%0d expected %b%b%0d",
               tag, sb[$].allow, sb[$].hit, sb[$].idx, al, ht, ix);
    end
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() != 0) begin
        e = sb.pop_front();
        checks++;
        if (allow_o !== e.allow || hit_o !== e.hit || hit_idx_o !== e.idx) begin
          errors++;
          $display("FAIL %s actual allow=%b hit=%b idx=%0d expected allow=%b hit=%b idx=%0d",
                   e.tag, allow_o, hit_o, hit_idx_o, e.allow, e.hit, e.idx);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all requirements actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : driver
    for (int n = 0; n < 8; n++) m_reg[n] = '0;
    m_dperm = 32'h2222_2222;
    m_iperm = 32'h2222_2222;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    probe_fix(32'h0000_0000, 2'd0, 1'b1, 1'b0, 1'b0, 3'd0, "R1 reset deny");
    probe_fix(32'hFFFF_FFC0, 2'd2, 1'b0, 1'b0, 1'b0, 3'd0, "R1 reset no hit");
    // R7 bypass
    probe(32'h1234_5678, 2'd1, 1'b0, 1'b0, "R7 bypass");

    // R2 16 MB window at 0x02000000, size code 23
    wr_cfg(4'd0, 32'h0200_002F);
    probe_fix(32'h02FF_FFFC, 2'd0, 1'b0, 1'b1, 1'b1, 3'd0, "R2 inside user read");
    probe_fix(32'h0300_0000, 2'd0, 1'b1, 1'b0, 1'b0, 3'd0, "R2 above window");
    probe_fix(32'h01FF_FFFF, 2'd0, 1'b1, 1'b0, 1'b0, 3'd0, "R2 below window");
    probe_fix(32'h0200_0000, 2'd1, 1'b0, 1'b0, 1'b1, 3'd0, "R5 code2 user write");
    probe_fix(32'h0200_0000, 2'd1, 1'b1, 1'b1, 1'b1, 3'd0, "R5 code2 priv write");
    probe_fix(32'h0200_0000, 2'd2, 1'b0, 1'b1, 1'b1, 3'd0, "R6 code2 user exec");

    // R4 disabled window
    wr_cfg(4'd1, 32'h0200_002E);
    probe_fix(32'h0200_0100, 2'd0, 1'b1, 1'b1, 1'b1, 3'd0, "R4 disabled no hit");

    // R3 R9 whole space at window 7 with data code 1
    wr_cfg(4'd7, 32'h0000_003F);
    wr_cfg(4'd8, 32'h1222_2222);
    probe_fix(32'hDEAD_BEC0, 2'd0, 1'b0, 1'b0, 1'b1, 3'd7, "R3 whole space user deny");
    probe_fix(32'hFFFF_FFFF, 2'd1, 1'b1, 1'b1, 1'b1, 3'd7, "R3 whole space priv write");
    // R8 overlap: window 0 grants despite window 7 denying
    probe_fix(32'h0280_0000, 2'd0, 1'b0, 1'b1, 1'b1, 3'd7, "R8 lower grants");
    probe_fix(32'h0280_0000, 2'd1, 1'b0, 1'b0, 1'b1, 3'd7, "R8 none grants");
    // R11 reserved kind
    probe_fix(32'h0280_0000, 2'd3, 1'b1, 1'b0, 1'b1, 3'd7, "R11 reserved kind");
    probe(32'h0280_0000, 2'd3, 1'b1, 1'b0, "R11 reserved bypass");

    // R10 ignored selectors
    for (int s = 10; s < 16; s++) wr_cfg(4'(s), 32'h0000_0000);
    probe_fix(32'h0280_0000, 2'd0, 1'b0, 1'b1, 1'b1, 3'd7, "R10 ignored selectors");

    // R2 low six bits never compared: size code 0 at 0x1000
    wr_cfg(4'd7, 32'h0000_0000);
    wr_cfg(4'd3, 32'h0000_1001);
    probe_fix(32'h0000_103F, 2'd0, 1'b0, 1'b1, 1'b1, 3'd3, "R2 low bits ignored");
    probe_fix(32'h0000_1040, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0, "R2 past 64 bytes");

    // R5 R6 sweep of every code through a whole-space window 5
    wr_cfg(4'd0, 32'h0);
    wr_cfg(4'd3, 32'h0);
    wr_cfg(4'd5, 32'h0000_003F);
    for (int c = 0; c < 16; c++) begin
      wr_cfg(4'd8, 32'(c) << 20);
      wr_cfg(4'd9, 32'(c) << 20);
      for (int k = 0; k < 4; k++) begin
        probe(32'h4000_0000, 2'(k), 1'b0, 1'b1, "R5 R6 code sweep user");
        probe(32'h4000_0000, 2'(k), 1'b1, 1'b1, "R5 R6 code sweep priv");
      end
    end

    // R8 R9 R10 mixed configurations
    for (int t = 0; t < 300; t++) begin
      logic [31:0] w;
      w = $urandom;
      w[5:1] = 5'($urandom_range(10, 30));
      wr_cfg(4'($urandom_range(0, 9)), (t % 7 == 0) ? $urandom : w);
      for (int p = 0; p < 4; p++) begin
        logic [31:0] a;
        a = (p < 2) ? (m_reg[$urandom_range(0, 7)] ^ 32'($urandom_range(0, 4095))) : $urandom;
        probe(a, 2'($urandom_range(0, 3)), 1'($urandom), 1'($urandom_range(0, 7) != 0),
              "R8 R9 mixed");
      end
    end

    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule